// File: doc/BRIEF.md
# Branch broadcast region filter

This block decides, for each traced instruction address, whether branch broadcasting is active. It holds a small control word with a mode flag and a mask that selects address range comparators. It also contains the comparators themselves: a bank of inclusive start/end pairs. A register-bus slave port reads and writes the control word. The port returns an error response while external trace access is not permitted, and it drops writes unless the trace unit is idle.

Each cycle the filter takes an optional address, tests it against every implemented comparator, and combines the hits for the selected comparators. In exclude mode the hits block broadcasting. In include mode the hits enable it. The decision appears one clock after the address. Comparators at or above `NUM_PAIRS` do not exist: their select bits read as zero and ignore writes.

Top module: `bb_region_filter`

## Requirements
- R1: After reset the control word reads 0x00000000. Every valid address is then reported active, because the filter is in exclude mode with no range selected.
- R2: The control word is laid out as follows. Bits 7:0 are the select mask, with bit m selecting comparator m. Bit 8 is the mode: 0 means exclude, 1 means include. Bits 31:9 always read zero, and written values there have no effect.
- R3: A select bit m with m >= `NUM_PAIRS` always reads zero, and writing 1 to it has no effect.
- R4: In exclude mode an address is active exactly when it lies outside every selected range. With an empty mask, every address is active.
- R5: In include mode an address is active exactly when it lies inside at least one selected range. With an empty mask, no address is active.
- R6: Comparator m hits when `start[m] <= addr <= end[m]`. Both bounds are inclusive, and the compare is unsigned.
- R7: An access to the register returns `bus_err`=1 and `bus_rdata`=0 when any of these holds: `ext_access_ok`=0, `os_lock`=1, or `core_powered`=0. Such a write leaves the control word unchanged.
- R8: A write while `unit_idle`=0 is dropped with `bus_err`=0, and the control word keeps its value. Reads are served in any unit state.
- R9: `bb_valid` and `bb_active` are registered. `bb_valid` equals `addr_valid` of the previous cycle, and `bb_active` is the decision for the address presented in that cycle.
- R10: Only byte offset 0x03C is decoded. An access at any other offset returns `bus_err`=0 and `bus_rdata`=0, and does not change the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte offset within the trace register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| bus_err | output | 1 | Error response, valid in the cycle of the access |
| ext_access_ok | input | 1 | External trace access permitted |
| os_lock | input | 1 | OS lock set |
| core_powered | input | 1 | Trace core powered |
| unit_idle | input | 1 | Trace unit in idle state |
| cmp_start | input | 8*ADDR_W | Start bounds, comparator m at bits [m*ADDR_W +: ADDR_W] |
| cmp_end | input | 8*ADDR_W | End bounds, same packing |
| addr_valid | input | 1 | Address present this cycle |
| addr | input | ADDR_W | Instruction address |
| bb_valid | output | 1 | Decision valid |
| bb_active | output | 1 | Branch broadcasting active for the address |

## Verification
The bench builds the block with `ADDR_W`=8 and `NUM_PAIRS`=3. This makes every 8-bit address reachable, and all eight mask combinations of the live comparators can be swept in both modes against overlapping and edge-touching ranges. Slots 3 to 7 are fed ranges that cover the whole address space, so any leak from an unimplemented comparator would change the include- and exclude-mode results. All 512 mode/mask write values are also written and read back to expose the masking of unimplemented and reserved bits.

// File: rtl/bb_region_filter.sv
module bb_region_filter #(
  parameter int NUM_PAIRS = 8,
  parameter int ADDR_W    = 32,
  parameter int BUS_AW    = 12,
  parameter logic [BUS_AW-1:0] REG_OFFSET = 'h03C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [BUS_AW-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_err,
  input  logic                  ext_access_ok,
  input  logic                  os_lock,
  input  logic                  core_powered,
  input  logic                  unit_idle,
  input  logic [8*ADDR_W-1:0]   cmp_start,
  input  logic [8*ADDR_W-1:0]   cmp_end,
  input  logic                  addr_valid,
  input  logic [ADDR_W-1:0]     addr,
  output logic                  bb_valid,
  output logic                  bb_active
);
  localparam int SLOTS = 8;
  localparam logic [8:0] ONE9 = 9'd1;
  localparam logic [8:0] IMPL9 = (ONE9 << NUM_PAIRS) - ONE9;
  localparam logic [SLOTS-1:0] IMPL_MASK = IMPL9[SLOTS-1:0];

  logic             mode_q;
  logic [SLOTS-1:0] mask_q;
  logic             hit, blocked, wr_en;
  logic [SLOTS-1:0] in_rng;
  logic             any_sel, decide;

  assign hit     = bus_sel && (bus_addr == REG_OFFSET);
  assign blocked = !ext_access_ok || os_lock || !core_powered;
  assign bus_err = hit && blocked;
  assign wr_en   = hit && !blocked && bus_wr && unit_idle;
  assign bus_rdata = (hit && !blocked && !bus_wr) ? {23'd0, mode_q, mask_q} : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      mask_q <= '0;
    end else if (wr_en) begin
      mode_q <= bus_wdata[8];
      mask_q <= bus_wdata[SLOTS-1:0] & IMPL_MASK;
    end
  end

  for (genvar m = 0; m < SLOTS; m++) begin : g_cmp
    if (m < NUM_PAIRS) begin : g_live
      logic [ADDR_W-1:0] lo, hi;
      assign lo = cmp_start[m*ADDR_W +: ADDR_W];
      assign hi = cmp_end[m*ADDR_W +: ADDR_W];
      assign in_rng[m] = (addr >= lo) && (addr <= hi);
    end else begin : g_none
      assign in_rng[m] = 1'b0;
    end
  end

  assign any_sel = |(in_rng & mask_q);
  assign decide  = mode_q ? any_sel : !any_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bb_valid  <= 1'b0;
      bb_active <= 1'b0;
    end else begin
      bb_valid  <= addr_valid;
      bb_active <= addr_valid && decide;
    end
  end

  assert_hold_unless_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mode_q) && $stable(mask_q)));

  assert_rdata_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[31:9] == 23'd0) && ((bus_rdata[SLOTS-1:0] & ~IMPL_MASK) == '0));

  assert_error_gating_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && blocked) |=> ($stable(mode_q) && $stable(mask_q)));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> bb_valid);

  assert_idle_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> (!bb_valid && !bb_active));

  assert_excl_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !mode_q && mask_q == '0) |=> bb_active);

  assert_incl_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && mode_q && mask_q == '0) |=> !bb_active);
endmodule

// File: tb/bb_region_filter_tb.sv
module bb_region_filter_tb;
  localparam int AW = 8;
  localparam int NP = 3;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_err;
  logic ext_access_ok = 1, os_lock = 0, core_powered = 1, unit_idle = 1;
  logic [8*AW-1:0] cmp_start, cmp_end;
  logic addr_valid = 0;
  logic [AW-1:0] addr = 0;
  logic bb_valid, bb_active;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bb_region_filter #(.NUM_PAIRS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .ext_access_ok(ext_access_ok), .os_lock(os_lock), .core_powered(core_powered),
    .unit_idle(unit_idle), .cmp_start(cmp_start), .cmp_end(cmp_end),
    .addr_valid(addr_valid), .addr(addr), .bb_valid(bb_valid), .bb_active(bb_active));

  int lo [8] = '{10, 30, 200, 0, 0, 0, 0, 0};
  int hi [8] = '{40, 90, 255, 255, 255, 255, 255, 255};
  always_comb
    for (int m = 0; m < 8; m++) begin
      cmp_start[m*AW +: AW] = AW'(lo[m]);
      cmp_end[m*AW +: AW]   = AW'(hi[m]);
    end

  function automatic bit expect_active(bit md, int msk, int a);
    bit any = 0;
    for (int m = 0; m < NP; m++)
      if (msk[m] && a >= lo[m] && a <= hi[m]) any = 1;
    return md ? any : !any;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [11:0] off, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = off; bus_wdata = d;
    #1 rd = bus_rdata; er = bus_err;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic probe(string req, bit md, int msk, int a);
    @(negedge clk);
    addr_valid = 1; addr = AW'(a);
    @(negedge clk);
    check(req, bb_valid, 1);
    check(req, bb_active, expect_active(md, msk, a));
    addr_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic er;
    repeat (3) @(negedge clk);
    check("R1 valid low in reset", bb_valid, 0);
    rst_n = 1;
    access(0, 12'h03C, 0, rd, er);
    check("R1 reset value", rd, 0);
    check("R1 no error", er, 0);
    for (int a = 0; a < 256; a += 37) probe("R1 reset all active", 0, 0, a);
    @(negedge clk);
    check("R9 valid follows addr_valid", bb_valid, 0);

    for (int v = 0; v < 512; v++) begin
      access(1, 12'h03C, 32'hFFFFFE00 | v, rd, er);
      check("R2 write ok", er, 0);
      access(0, 12'h03C, 0, rd, er);
      check("R2 R3 readback masked", rd, v & 32'h107);
    end

    for (int cfg = 0; cfg < 16; cfg++) begin
      access(1, 12'h03C, {23'd0, cfg[3], 8'(cfg[2:0] | 8'hF8)}, rd, er);
      for (int a = 0; a < 256; a++)
        probe(cfg[3] ? "R5 R6 include sweep" : "R4 R6 exclude sweep", cfg[3], cfg & 7, a);
    end

    access(1, 12'h03C, 32'h101, rd, er);
    for (int c = 0; c < 3; c++) begin
      ext_access_ok = (c != 0); os_lock = (c == 1); core_powered = (c != 2);
      access(1, 12'h03C, 32'h006, rd, er);
      check("R7 write error", er, 1);
      access(0, 12'h03C, 0, rd, er);
      check("R7 read error", er, 1);
      check("R7 read data zero", rd, 0);
      ext_access_ok = 1; os_lock = 0; core_powered = 1;
      access(0, 12'h03C, 0, rd, er);
      check("R7 value kept", rd, 32'h101);
    end

    unit_idle = 0;
    access(1, 12'h03C, 32'h002, rd, er);
    check("R8 no error when busy", er, 0);
    access(0, 12'h03C, 0, rd, er);
    check("R8 write dropped, read served", rd, 32'h101);
    probe("R8 filter unchanged", 1, 1, 20);
    unit_idle = 1;

    os_lock = 1;
    access(1, 12'h040, 32'h1FF, rd, er);
    check("R10 other offset no error", er, 0);
    os_lock = 0;
    access(0, 12'h040, 0, rd, er);
    check("R10 other offset reads zero", rd, 0);
    access(0, 12'h03C, 0, rd, er);
    check("R10 register untouched", rd, 32'h101);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule